// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

This unit sits beside the execute stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose branches resolve in execute. The architecture has exactly one branch delay slot: the instruction that follows a branch always executes, whether or not the branch is taken. From the branch class, the two register operands, the instruction address and the word offset, the unit decides in the same cycle whether fetch must be redirected and to which address.

All conditions are carry-free. Equality tests look for any differing bit. Sign tests look only at the sign bit of the first operand, plus a zero check where the test needs one. A general two-register less-than, which would need a carry chain, has no encoding.

The unit also remembers whether the instruction now in execute occupies a delay slot. When that instruction faults, the unit gives the exception logic two restart addresses: the faulting address and the address to continue at after it. For the slot of a taken branch, the second address is the branch target. A fault in execute suppresses the redirect and cancels any pending slot marking.

Top module: `slot_branch_resolver`

## Requirements
- R1: Class 1 (equal) is taken when `ex_rs` and `ex_rt` agree in every bit. Class 2 (not equal) is taken when they differ in any bit.
- R2: The sign classes test `ex_rs` only. Class 3 is taken when it is negative, class 4 when it is zero or positive, class 5 when it is negative or zero, and class 6 when it is positive and nonzero.
- R3: Class 7 is always taken. Class 0 marks a non-branch and is never taken. `br_taken` is low whenever `ex_valid` is low.
- R4: The target is `ex_pc + 4 + (sign-extended ex_off << 2)` and appears on `redirect_pc`. `redirect_valid` is high in the same cycle exactly when `br_taken` is high and no fault is present.
- R5: `ex_in_slot` is high for the first valid instruction after a valid, non-faulting instruction of nonzero class. Cycles with `ex_valid` low in between do not use up the marking. `ex_in_slot` is low in every other case, including after reset.
- R6: When `ex_valid` and `ex_fault` are high, `fault_valid` is high and `epc_first` equals `ex_pc`. Unless R7 applies, `epc_second` equals `ex_pc + 4`.
- R7: A fault on an instruction that sits in the delay slot of a taken branch gives `epc_second` equal to that branch's target.
- R8: A fault in execute forces `redirect_valid` low. A faulting branch does not mark the next instruction as a delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | A valid instruction is in execute |
| ex_op | input | 3 | Branch class (0 none, 1 eq, 2 ne, 3 ltz, 4 gez, 5 lez, 6 gtz, 7 always) |
| ex_rs | input | XLEN | First register operand |
| ex_rt | input | XLEN | Second register operand |
| ex_pc | input | XLEN | Address of the instruction in execute |
| ex_off | input | OFFW | Signed word offset of the branch |
| ex_fault | input | 1 | The instruction in execute faults |
| br_taken | output | 1 | Branch condition holds |
| redirect_valid | output | 1 | Fetch must be steered to redirect_pc |
| redirect_pc | output | XLEN | Branch target address |
| ex_in_slot | output | 1 | The instruction in execute is a delay-slot instruction |
| fault_valid | output | 1 | A fault is being reported |
| epc_first | output | XLEN | Restart address of the faulting instruction |
| epc_second | output | XLEN | Address to continue at after the restarted instruction |

## Verification
The hardest case to reach is a fault on the delay-slot instruction of a taken branch when bubbles separate it from the branch. Only in that case must the unit return a target it stored cycles earlier rather than the next sequential address. The stimulus sets up this case directly with a branch, two invalid cycles and then a faulting instruction. Random traffic then adds bubbles, faults and operand pairs forced to be equal or zero, so that the equal and less-or-equal-zero classes are taken often.

// File: rtl/slot_branch_resolver.sv
module slot_branch_resolver #(
  parameter int XLEN = 32,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic [2:0]      ex_op,
  input  logic [XLEN-1:0] ex_rs,
  input  logic [XLEN-1:0] ex_rt,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [OFFW-1:0] ex_off,
  input  logic            ex_fault,
  output logic            br_taken,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            ex_in_slot,
  output logic            fault_valid,
  output logic [XLEN-1:0] epc_first,
  output logic [XLEN-1:0] epc_second
);
  localparam int          EXTW    = XLEN - OFFW - 2;
  localparam logic [2:0]  OP_NONE = 3'd0;
  localparam logic [2:0]  OP_EQ   = 3'd1;
  localparam logic [2:0]  OP_NE   = 3'd2;
  localparam logic [2:0]  OP_LTZ  = 3'd3;
  localparam logic [2:0]  OP_GEZ  = 3'd4;
  localparam logic [2:0]  OP_LEZ  = 3'd5;
  localparam logic [2:0]  OP_GTZ  = 3'd6;
  localparam logic [2:0]  OP_JMP  = 3'd7;

  logic            mismatch, rs_neg, rs_zero, cond, fault_now;
  logic [XLEN-1:0] seq_pc, target;
  logic            slot_q, slot_tk_q;
  logic [XLEN-1:0] slot_tgt_q;

  assign mismatch = |(ex_rs ^ ex_rt);
  assign rs_neg   = ex_rs[XLEN-1];
  assign rs_zero  = ~|ex_rs;

  always_comb begin
    case (ex_op)
      OP_EQ:   cond = ~mismatch;
      OP_NE:   cond = mismatch;
      OP_LTZ:  cond = rs_neg;
      OP_GEZ:  cond = ~rs_neg;
      OP_LEZ:  cond = rs_neg | rs_zero;
      OP_GTZ:  cond = ~rs_neg & ~rs_zero;
      OP_JMP:  cond = 1'b1;
      default: cond = 1'b0;
    endcase
  end

  assign seq_pc    = ex_pc + XLEN'(4);
  assign target    = seq_pc + {{EXTW{ex_off[OFFW-1]}}, ex_off, 2'b00};
  assign fault_now = ex_valid & ex_fault;

  assign br_taken       = ex_valid & cond;
  assign redirect_valid = br_taken & ~fault_now;
  assign redirect_pc    = target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q     <= 1'b0;
      slot_tk_q  <= 1'b0;
      slot_tgt_q <= '0;
    end else if (ex_valid) begin
      slot_q     <= ~ex_fault & (ex_op != OP_NONE);
      slot_tk_q  <= cond;
      slot_tgt_q <= target;
    end
  end

  assign ex_in_slot  = ex_valid & slot_q;
  assign fault_valid = fault_now;
  assign epc_first   = ex_pc;
  assign epc_second  = (ex_in_slot & slot_tk_q) ? slot_tgt_q : seq_pc;

  a_r1_equal_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == OP_EQ && ex_rs == ex_rt) |-> br_taken);

  a_r3_always_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == OP_JMP && !ex_fault) |-> redirect_valid);

  a_r5_slot_follows_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op != OP_NONE && !ex_fault) |=> (ex_valid |-> ex_in_slot));

  a_r6_sequential_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !ex_in_slot) |-> (epc_second == epc_first + XLEN'(4)));

  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !redirect_valid);

  a_r8_no_slot_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (ex_valid |-> !ex_in_slot));
endmodule

// File: tb/test_slot_branch_resolver.sv
module test_slot_branch_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int OFFW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ex_valid = 1'b0;
  logic [2:0]      ex_op = '0;
  logic [XLEN-1:0] ex_rs = '0, ex_rt = '0, ex_pc = '0;
  logic [OFFW-1:0] ex_off = '0;
  logic            ex_fault = 1'b0;
  logic            br_taken, redirect_valid, ex_in_slot, fault_valid;
  logic [XLEN-1:0] redirect_pc, epc_first, epc_second;

  int tests = 0;
  int fails = 0;

  bit            m_slot = 0;
  bit            m_tk = 0;
  logic [31:0]   m_tgt = '0;

  slot_branch_resolver #(.XLEN(XLEN), .OFFW(OFFW)) i_slot_branch_resolver (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_op(ex_op),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_pc(ex_pc), .ex_off(ex_off),
    .ex_fault(ex_fault), .br_taken(br_taken), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .ex_in_slot(ex_in_slot),
    .fault_valid(fault_valid), .epc_first(epc_first), .epc_second(epc_second)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_cond(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd1: return a == b;
      3'd2: return a != b;
      3'd3: return $signed(a) < 0;
      3'd4: return $signed(a) >= 0;
      3'd5: return $signed(a) <= 0;
      3'd6: return $signed(a) > 0;
      3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(bit v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                      logic [31:0] pc, logic [15:0] off, bit f);
    bit tk, slot, flt;
    int sx;
    logic [31:0] tgt;
    @(negedge clk);
    ex_valid = v; ex_op = op; ex_rs = a; ex_rt = b;
    ex_pc = pc; ex_off = off; ex_fault = f;
    #(CLK_PERIOD/4);
    sx   = $signed(off);
    tgt  = pc + 32'd4 + 32'(sx * 4);
    tk   = v && ref_cond(op, a, b);
    slot = v && m_slot;
    flt  = v && f;
    if (op == 3'd1 || op == 3'd2) check("R1 taken", 32'(br_taken), 32'(tk));
    else if (op >= 3'd3 && op <= 3'd6) check("R2 taken", 32'(br_taken), 32'(tk));
    else check("R3 taken", 32'(br_taken), 32'(tk));
    if (flt) check("R8 redirect", 32'(redirect_valid), 0);
    else check("R4 redirect", 32'(redirect_valid), 32'(tk));
    if (tk) check("R4 target", redirect_pc, tgt);
    check("R5 in_slot", 32'(ex_in_slot), 32'(slot));
    check("R6 fault_valid", 32'(fault_valid), 32'(flt));
    if (flt) begin
      check("R6 epc_first", epc_first, pc);
      if (slot && m_tk) check("R7 epc_second", epc_second, m_tgt);
      else check("R6 epc_second", epc_second, pc + 32'd4);
    end
    @(posedge clk);
    if (v) begin
      m_slot = !f && op != 3'd0;
      m_tk   = ref_cond(op, a, b);
      m_tgt  = tgt;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset in_slot", 32'(ex_in_slot), 0);
    check("R3 reset taken", 32'(br_taken), 0);
    rst_n = 1'b1;
    // R1 equal / not equal
    step(1, 3'd1, 32'h1234, 32'h1234, 32'h100, 16'h0010, 0);
    step(1, 3'd0, 0, 0, 32'h104, 0, 0);
    step(1, 3'd1, 32'h1234, 32'h1235, 32'h108, 16'h0010, 0);
    step(1, 3'd2, 32'h8000_0000, 32'h0, 32'h10c, 16'hFFFC, 0);
    // R2 sign tests incl. zero for lez/gtz
    step(1, 3'd5, 32'h0, 32'h5, 32'h200, 16'h0001, 0);
    step(1, 3'd6, 32'h0, 32'h5, 32'h204, 16'h0001, 0);
    step(1, 3'd3, 32'hFFFF_FFFF, 0, 32'h208, 16'h8000, 0);
    step(1, 3'd4, 32'h7FFF_FFFF, 0, 32'h20c, 16'h7FFF, 0);
    // R7: taken branch, two bubbles, faulting slot instruction
    step(1, 3'd7, 0, 0, 32'h300, 16'h0040, 0);
    step(0, 3'd0, 0, 0, 32'h0, 0, 0);
    step(0, 3'd0, 0, 0, 32'h0, 0, 0);
    step(1, 3'd0, 0, 0, 32'h304, 0, 1);
    // R6: fault in slot of not-taken branch
    step(1, 3'd1, 32'h1, 32'h2, 32'h400, 16'h0040, 0);
    step(1, 3'd0, 0, 0, 32'h404, 0, 1);
    // R8: faulting branch, next not a slot
    step(1, 3'd7, 0, 0, 32'h500, 16'h0008, 1);
    step(1, 3'd0, 0, 0, 32'h600, 0, 0);
    // invalid branch: R3 not taken, R5 no marking
    step(0, 3'd7, 0, 0, 32'h700, 16'h0008, 0);
    step(1, 3'd0, 0, 0, 32'h704, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 2 == 0) ? a : $urandom;
      if ($urandom % 4 == 0) a = 0;
      step(($urandom % 5) != 0, 3'($urandom), a, b, $urandom & 32'hFFFF_FFFC,
           16'($urandom), ($urandom % 6) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule